// File: doc/BRIEF.md
# Spindle Drive Mode and Frame-Lock Controller

This block picks the drive applied to a disc spindle motor. A host command selects one of six operating modes: spin-up, hold-near-nominal, automatic constant-velocity servo, braking, stopped, and coarse speed correction. While the automatic servo is selected, the block uses its own frame-lock tracker to choose between a lead-in speed error and a normal speed error. The tracker counts frame-sync samples taken at one sixteenth of the frame clock. Lock is lost only after a run of consecutive misses. A single hit restores it.

Braking applies a programmable reverse drive. It ends in one of two ways. If the pulse-measurement logic reports that the longest run-length period has grown past its limit, the reverse drive is removed and a done flag rises. If that report does not arrive within a programmable number of cycles, the block forces the motor to zero drive for a second programmable period and then raises the done flag. The equalizers that produce the speed-error words and the demodulator that produces the sync strobe lie outside this block. They reach it as input words.

Top module: `spindle_ctl`

## Requirements
- R1: Command code 0 (stop), and the unused codes 6 and 7, give a drive of 0 and sub-mode 0.
- R2: A sync strobe with the hit bit set makes `locked` read 1 from the next cycle.
- R3: `locked` reads 0 after reset. It falls only on the cycle after the 8th consecutive strobe with the hit bit clear. Cycles without a strobe neither count as misses nor break a run of misses.
- R4: Command code 3 (auto servo) drives `err_normal` with sub-mode 4 while `locked` is 1, and drives `err_leadin` with sub-mode 3 while `locked` is 0.
- R5: Command code 4 (brake) drives `-brake_mag` with sub-mode 5. A cycle with `long_pat` high during this phase moves the block, from the next cycle, to drive 0 with sub-mode 5 and `brake_done` at 1.
- R6: If `long_pat` is not seen during the first `brake_limit` cycles of braking, the block enters forced stop: drive 0, sub-mode 7, `brake_done` 0. After `hold_limit` further cycles, `brake_done` reads 1 while drive stays 0 and sub-mode stays 7.
- R7: Any command other than 4 clears all brake progress and its timers, and `brake_done` reads 0. A later brake command starts again from reverse drive.
- R8: Command code 1 (kick) drives `kick_lvl` with sub-mode 1. Command code 2 (offset hold) drives `offset_lvl` with sub-mode 2.
- R9: Command code 5 (rough) drives `+rough_mag` when `rough_slow` is 1 and `-rough_mag` when it is 0, with sub-mode 6.
- R10: Once braking has reached forced stop or has finished, `long_pat` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cmd | input | 3 | Host mode command code |
| kick_lvl | input | DRV_W | Signed spin-up drive level |
| offset_lvl | input | DRV_W | Signed hold drive level |
| brake_mag | input | DRV_W-1 | Reverse drive magnitude for braking |
| rough_mag | input | DRV_W-1 | Drive magnitude for coarse correction |
| brake_limit | input | TMR_W | Braking cycles allowed before forced stop |
| hold_limit | input | TMR_W | Forced-stop cycles before the done flag |
| sync_strobe | input | 1 | Sync sample valid (frame clock / 16) |
| sync_hit | input | 1 | Sample found sync matching the frame counter |
| long_pat | input | 1 | Longest run-length period exceeded its limit |
| err_leadin | input | DRV_W | Signed lead-in speed error |
| err_normal | input | DRV_W | Signed normal speed error |
| rough_slow | input | 1 | 1 when the disc is too slow, 0 when too fast |
| drive | output | DRV_W | Signed spindle drive |
| locked | output | 1 | Frame-sync status, 1 when in sync |
| brake_done | output | 1 | Braking finished |
| sub_mode | output | 3 | Sub-mode: 0 stop, 1 kick, 2 offset, 3 lead-in, 4 normal, 5 brake, 6 rough, 7 forced stop |

## Verification
A miss counter that is off by one changes the cycle on which `locked` falls. In auto-servo mode it also switches the drive source on that same cycle, so a wrong count shows at the ports on the 8th miss. A brake timer with a wrong terminal value, or one that fails to clear, moves the step to sub-mode 7, or the rise of `brake_done`, by whole cycles. Such a fault is therefore visible within one timeout period of the start of braking. The bench's model tracks both counters independently and compares every output on every cycle, so each of these faults is caught on the first cycle it affects.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [2:0] {
        CMD_STOP   = 3'd0,
        CMD_KICK   = 3'd1,
        CMD_OFFSET = 3'd2,
        CMD_SERVO  = 3'd3,
        CMD_BRAKE  = 3'd4,
        CMD_ROUGH  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        SUB_STOP   = 3'd0,
        SUB_KICK   = 3'd1,
        SUB_OFFSET = 3'd2,
        SUB_LEADIN = 3'd3,
        SUB_NORMAL = 3'd4,
        SUB_BRAKE  = 3'd5,
        SUB_ROUGH  = 3'd6,
        SUB_FSTOP  = 3'd7
    } sub_e;

    typedef enum logic [1:0] {
        BRK_RUN  = 2'd0,
        BRK_DONE = 2'd1,
        BRK_HOLD = 2'd2,
        BRK_OVER = 2'd3
    } brk_e;

    // Unused command codes fall back to stop.
    function automatic cmd_e decode_cmd(input logic [2:0] raw);
        case (raw)
            3'd1:    return CMD_KICK;
            3'd2:    return CMD_OFFSET;
            3'd3:    return CMD_SERVO;
            3'd4:    return CMD_BRAKE;
            3'd5:    return CMD_ROUGH;
            default: return CMD_STOP;
        endcase
    endfunction

endpackage

// File: rtl/spm_sync_track.sv
module spm_sync_track #(
    parameter int MISS_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_strobe,
    input  logic sync_hit,
    output logic locked
);
    localparam int CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(MISS_LIMIT);

    logic [CW-1:0] miss_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_cnt <= LIM;
            locked   <= 1'b0;
        end else if (sync_strobe) begin
            if (sync_hit) begin
                miss_cnt <= '0;
                locked   <= 1'b1;
            end else if (miss_cnt != LIM) begin
                miss_cnt <= miss_cnt + 1'b1;
                if (miss_cnt + 1'b1 == LIM)
                    locked <= 1'b0;
            end
        end
    end

    p_hit_locks_r2: assert property (@(posedge clk) disable iff (rst)
        (sync_strobe && sync_hit) |=> locked);

    p_drop_needs_miss_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(sync_strobe && !sync_hit));

    p_idle_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        !sync_strobe |=> $stable(locked));

endmodule

// File: rtl/spm_brake_seq.sv
module spm_brake_seq
    import spm_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             long_pat,
    input  logic [TMR_W-1:0] brake_limit,
    input  logic [TMR_W-1:0] hold_limit,
    output brk_e             state
);
    logic [TMR_W-1:0] tmr;
    logic [TMR_W:0]   tmr_next;

    assign tmr_next = {1'b0, tmr} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state <= BRK_RUN;
            tmr   <= '0;
        end else begin
            case (state)
                BRK_RUN: begin
                    if (long_pat) begin
                        state <= BRK_DONE;
                    end else if (tmr_next >= {1'b0, brake_limit}) begin
                        state <= BRK_HOLD;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr_next[TMR_W-1:0];
                    end
                end
                BRK_HOLD: begin
                    if (tmr_next >= {1'b0, hold_limit})
                        state <= BRK_OVER;
                    else
                        tmr <= tmr_next[TMR_W-1:0];
                end
                default: state <= state;
            endcase
        end
    end

    p_flag_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (active && state == BRK_RUN && long_pat) |=> (state == BRK_DONE));

    p_hold_ignores_r10: assert property (@(posedge clk) disable iff (rst)
        (active && state == BRK_HOLD) |=> (state == BRK_HOLD || state == BRK_OVER || !$past(active)));

    p_exit_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !active |=> (state == BRK_RUN));

endmodule

// File: rtl/spm_drive_mux.sv
module spm_drive_mux
    import spm_pkg::*;
#(
    parameter int DRV_W = 12
) (
    input  cmd_e                    cmd,
    input  brk_e                    bstate,
    input  logic                    locked,
    input  logic signed [DRV_W-1:0] kick_lvl,
    input  logic signed [DRV_W-1:0] offset_lvl,
    input  logic [DRV_W-2:0]        brake_mag,
    input  logic [DRV_W-2:0]        rough_mag,
    input  logic signed [DRV_W-1:0] err_leadin,
    input  logic signed [DRV_W-1:0] err_normal,
    input  logic                    rough_slow,
    output logic signed [DRV_W-1:0] drive,
    output sub_e                    sub,
    output logic                    done
);
    logic signed [DRV_W-1:0] brake_rev;
    logic signed [DRV_W-1:0] rough_pos;

    assign brake_rev = -$signed({1'b0, brake_mag});
    assign rough_pos = $signed({1'b0, rough_mag});

    always_comb begin
        drive = '0;
        sub   = SUB_STOP;
        done  = 1'b0;
        case (cmd)
            CMD_KICK: begin
                drive = kick_lvl;
                sub   = SUB_KICK;
            end
            CMD_OFFSET: begin
                drive = offset_lvl;
                sub   = SUB_OFFSET;
            end
            CMD_SERVO: begin
                drive = locked ? err_normal : err_leadin;
                sub   = locked ? SUB_NORMAL : SUB_LEADIN;
            end
            CMD_BRAKE: begin
                case (bstate)
                    BRK_RUN:  begin drive = brake_rev; sub = SUB_BRAKE; end
                    BRK_DONE: begin sub = SUB_BRAKE; done = 1'b1; end
                    BRK_HOLD: begin sub = SUB_FSTOP; end
                    default:  begin sub = SUB_FSTOP; done = 1'b1; end
                endcase
            end
            CMD_ROUGH: begin
                drive = rough_slow ? rough_pos : -rough_pos;
                sub   = SUB_ROUGH;
            end
            default: begin
                drive = '0;
                sub   = SUB_STOP;
            end
        endcase
    end

endmodule

// File: rtl/spindle_ctl.sv
module spindle_ctl
    import spm_pkg::*;
#(
    parameter int DRV_W      = 12,
    parameter int TMR_W      = 16,
    parameter int MISS_LIMIT = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              mode_cmd,
    input  logic signed [DRV_W-1:0] kick_lvl,
    input  logic signed [DRV_W-1:0] offset_lvl,
    input  logic [DRV_W-2:0]        brake_mag,
    input  logic [DRV_W-2:0]        rough_mag,
    input  logic [TMR_W-1:0]        brake_limit,
    input  logic [TMR_W-1:0]        hold_limit,
    input  logic                    sync_strobe,
    input  logic                    sync_hit,
    input  logic                    long_pat,
    input  logic signed [DRV_W-1:0] err_leadin,
    input  logic signed [DRV_W-1:0] err_normal,
    input  logic                    rough_slow,
    output logic signed [DRV_W-1:0] drive,
    output logic                    locked,
    output logic                    brake_done,
    output logic [2:0]              sub_mode
);
    cmd_e cmd;
    brk_e bstate;
    sub_e sub;

    assign cmd = decode_cmd(mode_cmd);

    spm_sync_track #(.MISS_LIMIT(MISS_LIMIT)) u_sync (
        .clk(clk), .rst(rst), .sync_strobe(sync_strobe),
        .sync_hit(sync_hit), .locked(locked)
    );

    spm_brake_seq #(.TMR_W(TMR_W)) u_brake (
        .clk(clk), .rst(rst), .active(cmd == CMD_BRAKE),
        .long_pat(long_pat), .brake_limit(brake_limit),
        .hold_limit(hold_limit), .state(bstate)
    );

    spm_drive_mux #(.DRV_W(DRV_W)) u_mux (
        .cmd(cmd), .bstate(bstate), .locked(locked),
        .kick_lvl(kick_lvl), .offset_lvl(offset_lvl),
        .brake_mag(brake_mag), .rough_mag(rough_mag),
        .err_leadin(err_leadin), .err_normal(err_normal),
        .rough_slow(rough_slow), .drive(drive), .sub(sub),
        .done(brake_done)
    );

    assign sub_mode = sub;

    p_stop_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_cmd == 3'd0 || mode_cmd > 3'd5) |-> (drive == '0));

    p_fresh_brake_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_cmd) != 3'd4 && mode_cmd == 3'd4) |-> (!brake_done && sub_mode == 3'd5));

    p_reverse_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_cmd == 3'd4 && !brake_done && sub_mode == 3'd5) |-> (drive <= 0));

    p_fstop_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (sub_mode == 3'd7) |-> (drive == '0));

endmodule

// File: tb/spindle_ctl_test.sv
module spindle_ctl_test;
    localparam int DRV_W = 12;
    localparam int TMR_W = 16;

    logic clk = 0;
    logic rst = 1;
    logic [2:0] mode_cmd = 0;
    logic signed [DRV_W-1:0] kick_lvl = 0, offset_lvl = 0, err_leadin = 0, err_normal = 0;
    logic [DRV_W-2:0] brake_mag = 0, rough_mag = 0;
    logic [TMR_W-1:0] brake_limit = 5, hold_limit = 4;
    logic sync_strobe = 0, sync_hit = 0, long_pat = 0, rough_slow = 0;
    logic signed [DRV_W-1:0] drive;
    logic locked, brake_done;
    logic [2:0] sub_mode;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_locked, m_miss, m_bst, m_tmr;

    always #5 clk = ~clk;

    spindle_ctl #(.DRV_W(DRV_W), .TMR_W(TMR_W), .MISS_LIMIT(8)) uut (
        .clk(clk), .rst(rst), .mode_cmd(mode_cmd), .kick_lvl(kick_lvl),
        .offset_lvl(offset_lvl), .brake_mag(brake_mag), .rough_mag(rough_mag),
        .brake_limit(brake_limit), .hold_limit(hold_limit),
        .sync_strobe(sync_strobe), .sync_hit(sync_hit), .long_pat(long_pat),
        .err_leadin(err_leadin), .err_normal(err_normal), .rough_slow(rough_slow),
        .drive(drive), .locked(locked), .brake_done(brake_done), .sub_mode(sub_mode)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_locked = 0; m_miss = 8; m_bst = 0; m_tmr = 0;
            return;
        end
        if (sync_strobe) begin
            if (sync_hit) begin m_miss = 0; m_locked = 1; end
            else begin
                if (m_miss < 8) m_miss++;
                if (m_miss >= 8) m_locked = 0;
            end
        end
        if (mode_cmd != 3'd4) begin
            m_bst = 0; m_tmr = 0;
        end else if (m_bst == 0) begin
            if (long_pat) m_bst = 1;
            else if (m_tmr + 1 >= int'(brake_limit)) begin m_bst = 2; m_tmr = 0; end
            else m_tmr++;
        end else if (m_bst == 2) begin
            if (m_tmr + 1 >= int'(hold_limit)) m_bst = 3;
            else m_tmr++;
        end
    endtask

    task automatic compare();
        int ed, es, edone;
        string tg;
        ed = 0; es = 0; edone = 0;
        case (mode_cmd)
            3'd1: begin ed = int'(kick_lvl); es = 1; tg = "R8"; end
            3'd2: begin ed = int'(offset_lvl); es = 2; tg = "R8"; end
            3'd3: begin
                ed = m_locked ? int'(err_normal) : int'(err_leadin);
                es = m_locked ? 4 : 3; tg = "R4";
            end
            3'd4: begin
                case (m_bst)
                    0: begin ed = -int'(brake_mag); es = 5; tg = "R5 R7"; end
                    1: begin es = 5; edone = 1; tg = "R5"; end
                    2: begin es = 7; tg = "R6 R10"; end
                    default: begin es = 7; edone = 1; tg = "R6 R10"; end
                endcase
            end
            3'd5: begin
                ed = rough_slow ? int'(rough_mag) : -int'(rough_mag);
                es = 6; tg = "R9";
            end
            default: tg = "R1";
        endcase
        chk(tg, "drive", int'(drive), ed);
        chk(tg, "sub_mode", int'(sub_mode), es);
        chk((mode_cmd == 3'd4) ? tg : "R7", "brake_done", int'(brake_done), edone);
        chk("R2 R3", "locked", int'(locked), m_locked);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int seg_left, cur_cmd, hit_pct, lp_div;
        seg_left = 0; cur_cmd = 0; hit_pct = 50; lp_div = 30;
        m_locked = 0; m_miss = 8; m_bst = 0; m_tmr = 0;
        @(negedge clk);
        @(posedge clk); model_step();
        @(negedge clk);
        rst = 0;
        // reset state: non-sync, stopped, no brake flag (R1, R3)
        compare();
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (seg_left == 0) begin
                seg_left = 5 + int'($urandom_range(0, 55));
                cur_cmd = int'($urandom_range(0, 7));
                hit_pct = ($urandom_range(0, 1) == 1) ? 90 : 8;
                lp_div = int'($urandom_range(6, 80));
                brake_limit = TMR_W'($urandom_range(0, 20));
                hold_limit = TMR_W'($urandom_range(0, 12));
                kick_lvl = DRV_W'($urandom);
                offset_lvl = DRV_W'($urandom);
                brake_mag = (DRV_W-1)'($urandom);
                rough_mag = (DRV_W-1)'($urandom);
            end
            seg_left--;
            mode_cmd = 3'(cur_cmd);
            sync_strobe = ($urandom_range(0, 3) == 0);
            sync_hit = (int'($urandom_range(0, 99)) < hit_pct);
            long_pat = ($urandom_range(0, lp_div) == 0);
            err_leadin = DRV_W'($urandom);
            err_normal = DRV_W'($urandom);
            rough_slow = $urandom_range(0, 1) == 1;
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule